// File: doc/BRIEF.md
# Triggered Run-to-Modulo Tick Counter

This block is a one-shot event counter that lives entirely on a fast system clock. It sits idle, with its ready flag raised, until a rising edge appears on the start input. It then counts rising edges of a slow tick input until the count would reach a programmable modulo. At that point it clears itself and returns to idle.

The slow tick never drives a clock pin. Both the tick and the start line are resynchronized into the system clock domain by a two-stage flip-flop chain. A third delayed sample is compared with the second to find a rising edge. Each detected edge becomes a single-cycle enable for the controller. Because the start line is edge-detected, a start button held down through the end of a run does not launch a second run.

The count is driven on the output at all times. Every pin is a plain control or status signal, so the block has no valid/ready stream interface and no back-pressure.

Top module: `tick_run_counter`

## Requirements
- R1: With `rst` high at a rising clock edge, the block is in idle after that edge: `ready` is 1, `count` is 0 and the synchronizer stages are cleared.
- R2: In idle, a 0-to-1 transition on `start_in` moves the block into the counting state. `ready` falls on the third rising clock edge after `start_in` is first sampled high. A tick edge detected in that same cycle does not advance the count.
- R3: In the counting state, each 0-to-1 transition of `tick_in` raises `count` by exactly one, however many clock cycles the tick stays high. The new value appears on the third rising clock edge after `tick_in` is first sampled high.
- R4: In the counting state, when `count` equals MODULO-1 and a tick edge is detected, `count` returns to 0 and `ready` returns to 1 on the same clock edge.
- R5: Tick edges arriving while idle are ignored: `count` stays 0 and `ready` stays 1.
- R6: Keeping `start_in` high after a run ends does not start a new run; only a fresh 0-to-1 transition does.
- R7: A rising edge on `start_in` while counting is ignored: the count is neither cleared nor restarted.
- R8: `count` never reaches MODULO, and it reads 0 whenever `ready` is 1.
- R9: A synchronous reset in the middle of a run returns the block to idle with `count` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_in | input | 1 | Slow pacing input, asynchronous to `clk` |
| start_in | input | 1 | Run request, asynchronous to `clk`, edge-sensitive |
| ready | output | 1 | High while idle and able to accept a start |
| count | output | WIDTH | Current count value |

## Verification
Both input paths have the same latency. An input first sampled high at rising edge k is captured by the synchronizer at edges k and k+1. Its effect on `ready` or `count` then lands at edge k+2, which is the third edge counting edge k itself. The bench therefore changes inputs on falling edges and waits four falling edges before it compares any output, so every vector is read after its result has settled. A directed latency test samples the count both one edge early and exactly on the due edge, so a missing or an extra pipeline stage is caught.

// File: rtl/tick_run_pkg.sv
package tick_run_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;
endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[LAST-1:0], d};
  end

  assign rise = sr[LAST-1] & ~sr[LAST];

  // R3: a detected edge is a single-cycle pulse
  a_r3_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import tick_run_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int MODULO = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_pls,
  input  logic             tick_pls,
  output logic             idle,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] TOP = WIDTH'(MODULO - 1);

  run_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start_pls) st <= ST_RUN;
        ST_RUN: if (tick_pls) begin
          if (cnt == TOP) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle = (st == ST_IDLE);

  // R4: the last step wraps to zero and returns to idle
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && tick_pls && cnt == TOP) |=> (cnt == '0 && idle));
  // R3: one step per enabled cycle
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && tick_pls && cnt != TOP) |=> (cnt == WIDTH'($past(cnt) + 1'b1)));
  // R3: no step without an edge
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_pls |=> $stable(cnt));
  // R8: idle reads zero and the count stays below the modulo
  a_r8_bounds: assert property (@(posedge clk) disable iff (rst)
    (cnt < TOP + 1'b1) && (!idle || cnt == '0));
  // R7: start while running keeps the run
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && start_pls && !tick_pls) |=> (st == ST_RUN && $stable(cnt)));
endmodule

// File: rtl/tick_run_counter.sv
module tick_run_counter #(
  parameter int WIDTH     = 8,
  parameter int MODULO    = 50,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             start_in,
  output logic             ready,
  output logic [WIDTH-1:0] count
);
  localparam int N_IN = 2;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise_out;

  assign raw_in = {start_in, tick_in};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    sync_edge #(.STAGES(SYNC_STGS)) u_se (
      .clk  (clk),
      .rst  (rst),
      .d    (raw_in[g]),
      .rise (rise_out[g])
    );
  end

  run_ctrl #(.WIDTH(WIDTH), .MODULO(MODULO)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_pls (rise_out[1]),
    .tick_pls  (rise_out[0]),
    .idle      (ready),
    .cnt       (count)
  );

  // R1: reset forces idle and a zero count
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (ready && count == '0));
endmodule

// File: tb/sim_tick_run_counter.sv
`timescale 1ns/1ps
module sim_tick_run_counter;
  localparam int W   = 8;
  localparam int MOD = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_in = 1'b0;
  logic start_in = 1'b0;
  logic ready;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_run_counter #(.WIDTH(W), .MODULO(MOD)) u0 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .start_in(start_in),
    .ready(ready), .count(count)
  );

  // {start, tick, expected ready, expected count}
  localparam int NV = 16;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 8'd0},  // idle
    {1'b0, 1'b1, 1'b1, 8'd0},  // R5 tick while idle
    {1'b0, 1'b0, 1'b1, 8'd0},
    {1'b1, 1'b0, 1'b0, 8'd0},  // R2 start
    {1'b0, 1'b1, 1'b0, 8'd1},  // R3
    {1'b0, 1'b0, 1'b0, 8'd1},
    {1'b0, 1'b1, 1'b0, 8'd2},  // R3
    {1'b1, 1'b0, 1'b0, 8'd2},  // R7 start while running
    {1'b1, 1'b1, 1'b0, 8'd3},  // R3 start held
    {1'b1, 1'b0, 1'b0, 8'd3},
    {1'b1, 1'b1, 1'b1, 8'd0},  // R4 wrap
    {1'b1, 1'b0, 1'b1, 8'd0},  // R6 held start
    {1'b1, 1'b1, 1'b1, 8'd0},  // R6
    {1'b0, 1'b0, 1'b1, 8'd0},
    {1'b1, 1'b1, 1'b0, 8'd0},  // R2 start and tick together
    {1'b0, 1'b0, 1'b0, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    edges(2);
    rst = 1'b0;
    edges(1);
    chk("R1 ready after reset", ready, 1);
    chk("R1 count after reset", count, 0);

    for (int i = 0; i < NV; i++) begin
      start_in = VEC[i][10];
      tick_in  = VEC[i][9];
      edges(4);
      chk($sformatf("R2/R3/R4 vec %0d ready", i), ready, VEC[i][8]);
      chk($sformatf("R3/R5/R6/R7 vec %0d count", i), count, VEC[i][7:0]);
      chk($sformatf("R8 vec %0d below modulo", i), int'(count < MOD), 1);
    end

    // R3 latency: result due on the third edge
    tick_in = 1'b1;
    edges(2);
    chk("R3 not before third edge", count, 0);
    edges(1);
    chk("R3 on third edge", count, 1);
    // R3 long high gives one step
    edges(20);
    chk("R3 long tick single step", count, 1);
    tick_in = 1'b0;
    edges(4);

    // R9 reset mid-run
    rst = 1'b1;
    edges(1);
    rst = 1'b0;
    chk("R9 ready after mid-run reset", ready, 1);
    chk("R9 count after mid-run reset", count, 0);

    // R2 latency on start
    start_in = 1'b1;
    edges(2);
    chk("R2 ready before third edge", ready, 1);
    edges(1);
    chk("R2 ready falls on third edge", ready, 0);
    start_in = 1'b0;
    edges(4);

    // R4 full run to modulo
    for (int k = 0; k < MOD; k++) begin
      tick_in = 1'b1; edges(4);
      tick_in = 1'b0; edges(4);
    end
    chk("R4 ready after full run", ready, 1);
    chk("R8 count zero in idle", count, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule